// File: doc/BRIEF.md
# DDR SDRAM Clock-Enable Power State Controller

This block follows the clock-enable (CKE) side of a DDR SDRAM device. It watches the CKE level sampled in the previous and the current cycle, the chip-select/RAS/CAS/WE command lines, and a flag that reports whether every bank is idle. From these inputs it keeps track of which operating state the device is in: running, power-down, self-refresh, recovering from self-refresh, or clock suspend.

A falling CKE leads to a different state depending on the command issued in the same cycle and on whether all banks are idle. Leaving self-refresh is modelled as a synchronous transition. It is followed by a recovery window of `TRC_CYCLES` clocks, and the ready flag stays low for that whole window. A gate output tells the rest of the device when its internal clock should run. A one-cycle pulse flags every forbidden transition.

All outputs are registered. A decision made from the inputs at clock edge k shows up on the outputs right after edge k.

Top module: `cke_power_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (running), `clk_gate_en` is 1, `sr_ready` is 1 and `illegal_evt` is 0. The state codes are 0 running, 1 power-down, 2 self-refresh, 3 clock suspend and 4 self-refresh recovery.
- R2: In the running state, with `banks_idle` high, CKE falling (`cke_prev`=1, `cke_now`=0) with a deselect command (`cs_n`=1) or a NOP (`cs_n,ras_n,cas_n,we_n` = 0,1,1,1) enters power-down, and `clk_gate_en` goes to 0.
- R3: In the running state, with `banks_idle` high, CKE falling with the refresh encoding (`cs_n,ras_n,cas_n,we_n` = 0,0,0,1) enters self-refresh, with `clk_gate_en` 0 and `sr_ready` 0.
- R4: In the running state, with `banks_idle` high, CKE falling with any other command raises `illegal_evt` for exactly one cycle and leaves the state at running.
- R5: In the running state, with `banks_idle` low, CKE falling enters clock suspend whatever the command, with `clk_gate_en` 0. Suspend is held while CKE stays low, and CKE rising returns the state to running.
- R6: Power-down is held while CKE stays low. CKE rising returns the state to running whatever the command.
- R7: Self-refresh is held for as long as CKE stays low.
- R8: In self-refresh, CKE rising with a deselect or a NOP enters recovery, where `clk_gate_en` is 1 and `sr_ready` is 0. After exactly `TRC_CYCLES` cycles in recovery the state returns to running with `sr_ready` 1.
- R9: In self-refresh, CKE rising with any other command pulses `illegal_evt` and the state stays in self-refresh.
- R10: CKE high in both the previous and the current cycle keeps the running state and raises no `illegal_evt`, whatever the command or the bank status.
- R11: CKE falling during recovery pulses `illegal_evt`. The recovery count is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_prev | input | 1 | CKE level sampled in the previous cycle |
| cke_now | input | 1 | CKE level sampled in the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | High when every bank is idle |
| pwr_state | output | 3 | Current power state code |
| clk_gate_en | output | 1 | Internal clock enable |
| sr_ready | output | 1 | Low during self-refresh and its recovery |
| illegal_evt | output | 1 | One-cycle pulse on a forbidden transition |

## Verification
The bench drives a falling CKE three ways: with busy banks, with idle banks and a NOP or deselect, and with the refresh encoding. A design that ignored the bank flag would put a busy device into power-down, and one that decoded the command wrongly would choose the wrong low-power state. It also tries to leave self-refresh with a command other than a NOP or deselect, and it drops CKE in the middle of recovery. A faulty design would either leave self-refresh silently or restart or skip its recovery count. The exact length of the recovery window is checked cycle by cycle, so an off-by-one timer shows up as `sr_ready` rising one cycle early or one cycle late.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [2:0] {
        PS_RUN  = 3'd0,
        PS_PDN  = 3'd1,
        PS_SREF = 3'd2,
        PS_SUSP = 3'd3,
        PS_SRX  = 3'd4
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e st;
        logic       gate;
        logic       ready;
        logic       illegal;
    } ctl_regs_t;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode (
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic cmd_quiet,
    output logic cmd_refresh
);
    always_comb begin
        // Deselect, or NOP with the chip selected
        cmd_quiet   = cs_n | (ras_n & cas_n & we_n);
        // Row and column strobes low, write enable high
        cmd_refresh = ~cs_n & ~ras_n & ~cas_n & we_n;
    end
endmodule

// File: rtl/cke_edge_classify.sv
module cke_edge_classify (
    input  logic cke_prev,
    input  logic cke_now,
    output logic cke_fall,
    output logic cke_rise
);
    always_comb begin
        cke_fall = cke_prev & ~cke_now;
        cke_rise = ~cke_prev & cke_now;
    end
endmodule

// File: rtl/cke_recovery_timer.sv
module cke_recovery_timer #(
    parameter int COUNT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(COUNT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        done = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: the count never exceeds its load value
    assert_cnt_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL);

    // R8: a load always starts a full window
    assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == LOAD_VAL);
endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
    import cke_pwr_pkg::*;
#(
    parameter int TRC_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke_prev,
    input  logic       cke_now,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       banks_idle,
    output logic [2:0] pwr_state,
    output logic       clk_gate_en,
    output logic       sr_ready,
    output logic       illegal_evt
);
    localparam ctl_regs_t RESET_REGS = '{st: PS_RUN, gate: 1'b1, ready: 1'b1, illegal: 1'b0};

    ctl_regs_t regs_d, regs_q;
    logic cmd_quiet, cmd_refresh;
    logic cke_fall, cke_rise;
    logic tmr_load, tmr_done;

    cke_cmd_decode u_dec (
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .cmd_quiet   (cmd_quiet),
        .cmd_refresh (cmd_refresh)
    );

    cke_edge_classify u_edge (
        .cke_prev (cke_prev),
        .cke_now  (cke_now),
        .cke_fall (cke_fall),
        .cke_rise (cke_rise)
    );

    cke_recovery_timer #(.COUNT(TRC_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (regs_q.st == PS_SRX),
        .done  (tmr_done)
    );

    always_comb begin
        regs_d         = regs_q;
        regs_d.illegal = 1'b0;
        tmr_load       = 1'b0;
        unique case (regs_q.st)
            PS_RUN: begin
                if (cke_fall) begin
                    if (!banks_idle)
                        regs_d.st = PS_SUSP;
                    else if (cmd_quiet)
                        regs_d.st = PS_PDN;
                    else if (cmd_refresh)
                        regs_d.st = PS_SREF;
                    else
                        regs_d.illegal = 1'b1;
                end
            end
            PS_PDN: begin
                if (cke_rise) regs_d.st = PS_RUN;
            end
            PS_SREF: begin
                if (cke_rise) begin
                    if (cmd_quiet) begin
                        regs_d.st = PS_SRX;
                        tmr_load  = 1'b1;
                    end else begin
                        regs_d.illegal = 1'b1;
                    end
                end
            end
            PS_SRX: begin
                if (cke_fall) regs_d.illegal = 1'b1;
                if (tmr_done) regs_d.st = PS_RUN;
            end
            PS_SUSP: begin
                if (cke_rise) regs_d.st = PS_RUN;
            end
            default: regs_d.st = PS_RUN;
        endcase
        regs_d.gate  = !(regs_d.st inside {PS_PDN, PS_SREF, PS_SUSP});
        regs_d.ready = !(regs_d.st inside {PS_SREF, PS_SRX});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_REGS;
        else        regs_q <= regs_d;
    end

    assign pwr_state   = regs_q.st;
    assign clk_gate_en = regs_q.gate;
    assign sr_ready    = regs_q.ready;
    assign illegal_evt = regs_q.illegal;

    // R5: with busy banks a running device never enters a deep low-power state
    assert_busy_no_deep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == PS_RUN && !banks_idle) |=> regs_q.st inside {PS_RUN, PS_SUSP});

    // R7: self-refresh is held while CKE stays low
    assert_sref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == PS_SREF && !cke_now) |=> regs_q.st == PS_SREF);

    // R4: an illegal event outside recovery leaves the state where it was
    assert_illegal_keeps_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.illegal && $past(regs_q.st) != PS_SRX) |-> regs_q.st == $past(regs_q.st));

    // R8: the ready flag and the gate agree with the registered state
    assert_ready_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ready == !(pwr_state inside {3'd2, 3'd4}));

    assert_gate_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_en == !(pwr_state inside {3'd1, 3'd2, 3'd3}));

    // R10: steady high CKE in running raises no illegal event
    assert_steady_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == PS_RUN && cke_prev && cke_now) |=> (regs_q.st == PS_RUN && !regs_q.illegal));
endmodule

// File: tb/cke_power_ctrl_test.sv
module cke_power_ctrl_test;
    localparam int TRC = 5;

    localparam logic [3:0] C_DESEL = 4'b1111;
    localparam logic [3:0] C_NOP   = 4'b0111;
    localparam logic [3:0] C_REF   = 4'b0001;
    localparam logic [3:0] C_ACT   = 4'b0011;
    localparam logic [3:0] C_READ  = 4'b0101;

    localparam logic [2:0] S_RUN = 3'd0, S_PDN = 3'd1, S_SREF = 3'd2, S_SUSP = 3'd3, S_SRX = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_prev = 1'b1, cke_now = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic banks_idle = 1'b1;
    logic [2:0] pwr_state;
    logic clk_gate_en, sr_ready, illegal_evt;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [2:0] st;
        logic       gate;
        logic       ready;
        logic       ill;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    cke_power_ctrl #(.TRC_CYCLES(TRC)) uut (
        .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_now(cke_now),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .banks_idle(banks_idle), .pwr_state(pwr_state), .clk_gate_en(clk_gate_en),
        .sr_ready(sr_ready), .illegal_evt(illegal_evt)
    );

    task automatic compare(input exp_t e);
        n_cmp++;
        if (pwr_state !== e.st || clk_gate_en !== e.gate || sr_ready !== e.ready || illegal_evt !== e.ill) begin
            n_bad++;
            $display("FAIL %s: got st=%0d gate=%0b rdy=%0b ill=%0b, expected st=%0d gate=%0b rdy=%0b ill=%0b",
                     e.tag, pwr_state, clk_gate_en, sr_ready, illegal_evt, e.st, e.gate, e.ready, e.ill);
        end
    endtask

    task automatic step(input logic cp, input logic cn, input logic [3:0] cmd, input logic idle,
                        input logic [2:0] est, input logic eill, input string tag);
        exp_t e;
        @(negedge clk);
        cke_prev = cp; cke_now = cn;
        {cs_n, ras_n, cas_n, we_n} = cmd;
        banks_idle = idle;
        e.st    = est;
        e.gate  = !(est == S_PDN || est == S_SREF || est == S_SUSP);
        e.ready = !(est == S_SREF || est == S_SRX);
        e.ill   = eill;
        e.tag   = tag;
        q.push_back(e);
    endtask

    // Monitor: one expected item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.st = S_RUN; r.gate = 1'b1; r.ready = 1'b1; r.ill = 1'b0; r.tag = "R1 reset";
        compare(r);
        rst_n = 1'b1;

        step(1, 1, C_NOP,   1, S_RUN,  0, "R10 steady high nop");
        step(1, 1, C_ACT,   0, S_RUN,  0, "R10 steady high act busy");
        step(1, 0, C_READ,  1, S_RUN,  1, "R4 fall with read");
        step(1, 1, C_NOP,   1, S_RUN,  0, "R4 pulse single cycle");
        step(1, 0, C_NOP,   1, S_PDN,  0, "R2 fall nop");
        step(0, 0, C_NOP,   1, S_PDN,  0, "R6 hold power-down");
        step(0, 1, C_ACT,   1, S_RUN,  0, "R6 exit with act");
        step(1, 0, C_DESEL, 1, S_PDN,  0, "R2 fall deselect");
        step(0, 1, C_READ,  0, S_RUN,  0, "R6 exit with read");
        step(1, 0, C_NOP,   0, S_SUSP, 0, "R5 fall busy nop");
        step(0, 0, C_ACT,   0, S_SUSP, 0, "R5 hold suspend");
        step(0, 1, C_ACT,   0, S_RUN,  0, "R5 exit suspend");
        step(1, 0, C_REF,   0, S_SUSP, 0, "R5 fall busy refresh");
        step(0, 1, C_NOP,   0, S_RUN,  0, "R5 exit suspend again");
        step(1, 0, C_REF,   1, S_SREF, 0, "R3 enter self-refresh");
        step(0, 0, C_NOP,   1, S_SREF, 0, "R7 hold self-refresh");
        step(0, 0, C_ACT,   1, S_SREF, 0, "R7 hold with act");
        step(0, 1, C_ACT,   1, S_SREF, 1, "R9 bad exit");
        step(0, 0, C_NOP,   1, S_SREF, 0, "R7 hold after bad exit");
        step(0, 1, C_NOP,   1, S_SRX,  0, "R8 exit to recovery");
        step(1, 1, C_NOP,   1, S_SRX,  0, "R8 recovery 2");
        step(1, 0, C_NOP,   1, S_SRX,  1, "R11 fall in recovery");
        step(1, 1, C_NOP,   1, S_SRX,  0, "R8 recovery 4");
        step(1, 1, C_NOP,   1, S_SRX,  0, "R8 recovery 5");
        step(1, 1, C_NOP,   1, S_RUN,  0, "R8 ready after window");
        step(1, 0, C_REF,   1, S_SREF, 0, "R3 enter again");
        step(0, 1, C_DESEL, 1, S_SRX,  0, "R8 exit deselect");
        for (int i = 0; i < TRC - 1; i++)
            step(1, 1, C_NOP, 1, S_SRX, 0, "R8 recovery run");
        step(1, 1, C_NOP,   1, S_RUN,  0, "R8 ready again");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: got %0d pending items, expected 0", q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule